// File: doc/BRIEF.md
# Embedded Operation Polling Status

This block sits on the read path of a flash-style memory device. While an internal program or erase runs, it stands in front of the array. Any read the host makes then returns a single status word instead of stored data. The host can poll that word to see several things: whether the operation is still running, whether an erase has been parked, and whether the operation has failed by timing out. A separate ready output gives the same busy indication without a read.

The operation sequencer is represented by a few pulses: start (with the operation kind, target sector and the polarity bit of the programmed word), done, timeout, suspend, resume and a reset command. Reads are marked by a read strobe. The sector field of the read address selects between status and array data. The array's data is supplied on an input and passed through whenever no overlay applies.

Status word layout, all other bits 0: bit 7 is the polarity bit, bit 6 is the general toggle, bit 5 is the timeout flag, and bit 2 is the erase-sector toggle.

Top module: `eo_poll_status`

## Requirements
- R1: While an operation is busy or timed out, every read returns the status word, whatever the sector. Bits other than 7, 6, 5 and 2 read 0.
- R2: Bit 7 of the status word depends on the situation. During a program it is the inverse of the programmed word's bit 7. During an erase it is 0. On a read of the erase-suspended sector it is 1.
- R3: The read data register loads on the clock edge where the read strobe is first sampled high after being low. At all other times it holds its value.
- R4: Bit 6 is 0 on the first read after a start and alternates on each later read while busy or timed out. It does not change while suspended or idle.
- R5: Bit 2 alternates only on reads whose sector equals the erased sector, while an erase is busy, suspended or timed out. All other reads leave it unchanged. It is 0 after each start.
- R6: A timeout pulse while busy sets bit 5. The block then stays busy and ignores done and suspend. A reset command returns it to idle with array reads.
- R7: A suspend request while busy removes the overlay, so reads return array data. The one exception is the erase-suspended sector, which still shows status. A resume request restores the overlay.
- R8: Out of reset, ready is 1 and read data is 0. Ready drops on the edge that accepts a start or a resume. It rises one cycle after the block enters idle or suspended.
- R9: If several events arrive in the same busy cycle, timeout takes priority over done, and done over suspend. A start is ignored unless the block is idle. A reset command is ignored unless the block has timed out.
- R10: When idle, for example after completion, reads return the array data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start pulse for an operation |
| op_kind | input | 1 | 0 = program, 1 = erase |
| op_sector | input | SECT_W | Sector targeted by the operation |
| op_data7 | input | 1 | Bit 7 of the word being programmed |
| op_done | input | 1 | Operation completion pulse |
| op_timeout | input | 1 | Operation timeout pulse |
| suspend_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| reset_cmd | input | 1 | Reset command pulse |
| rd_strobe | input | 1 | Read strobe, one read per rising level |
| rd_sect | input | SECT_W | Sector field of the read address |
| array_data | input | DATA_W | Array data for the read address |
| rd_data | output | DATA_W | Registered read data returned to the host |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
A wrong internal state shows up on the next read. If the state machine drifts, the first strobe afterwards returns array data where status is expected, or the reverse. A toggle flop that flips at the wrong time shows a repeated bit 6 or bit 2 value on the following read. The ready flag diverges from the model one cycle after any wrong transition. Because the bench model is compared on every clock, a fault is reported within one or two cycles of the read or event that exposes it.

// File: rtl/eo_poll_pkg.sv
// Shared types and status-word bit positions for the polling status block.
// Assumes DATA_W of the users is at least 8.
package eo_poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_SUSP = 2'd2,
        ST_FAIL = 2'd3
    } eo_state_t;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } eo_kind_t;

    localparam int BIT_POLL = 7;
    localparam int BIT_TGL  = 6;
    localparam int BIT_TMO  = 5;
    localparam int BIT_ETGL = 2;
    localparam int STATUS_MIN_W = 8;
endpackage

// File: rtl/eo_op_fsm.sv
// Operation state tracker: follows start/done/timeout/suspend/resume/reset
// events, captures the operation context and produces the ready flag.
// Assumes event inputs are single-cycle pulses.
module eo_op_fsm
    import eo_poll_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  eo_kind_t          op_kind,
    input  logic [SECT_W-1:0] op_sector,
    input  logic              op_data7,
    input  logic              op_done,
    input  logic              op_timeout,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              reset_cmd,
    output eo_state_t         st,
    output eo_kind_t          kind,
    output logic [SECT_W-1:0] sect,
    output logic              pd7,
    output logic              clr_tgl,
    output logic              ready
);
    eo_state_t         st_q, st_d;
    eo_kind_t          kind_q;
    logic [SECT_W-1:0] sect_q;
    logic              pd7_q;
    logic              ready_q;
    logic              accept;
    logic              wake;

    assign accept = (st_q == ST_IDLE) && op_start;
    assign wake   = accept || ((st_q == ST_SUSP) && resume_req);

    // Next-state selection with timeout > done > suspend priority.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (op_start) st_d = ST_BUSY;
            ST_BUSY: begin
                if (op_timeout)       st_d = ST_FAIL;
                else if (op_done)     st_d = ST_IDLE;
                else if (suspend_req) st_d = ST_SUSP;
            end
            ST_SUSP: if (resume_req) st_d = ST_BUSY;
            ST_FAIL: if (reset_cmd)  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Capture the operation context when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_PROG;
            sect_q <= '0;
            pd7_q  <= 1'b0;
        end else if (accept) begin
            kind_q <= op_kind;
            sect_q <= op_sector;
            pd7_q  <= op_data7;
        end
    end

    // Ready flag: drops at once on start/resume, rises a cycle after idle or suspend.
    always_ff @(posedge clk) begin
        if (!rst_n)    ready_q <= 1'b1;
        else if (wake) ready_q <= 1'b0;
        else           ready_q <= (st_q == ST_IDLE) || (st_q == ST_SUSP);
    end

    assign st      = st_q;
    assign kind    = kind_q;
    assign sect    = sect_q;
    assign pd7     = pd7_q;
    assign clr_tgl = accept;
    assign ready   = ready_q;
endmodule

// File: rtl/eo_toggle_gen.sv
// Read-edge detector and the two toggle flops. Toggles advance once per
// read strobe rise, not per clock. Assumes the strobe is synchronous to clk.
module eo_toggle_gen
    import eo_poll_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_strobe,
    input  logic      clr,
    input  eo_state_t st,
    input  eo_kind_t  kind,
    input  logic      in_sector,
    output logic      fire,
    output logic      tgl,
    output logic      etgl
);
    logic strb_q;
    logic active;

    assign fire   = rd_strobe && !strb_q;
    assign active = (st == ST_BUSY) || (st == ST_FAIL);

    // Previous strobe sample, kept through reset so edge detection is clean.
    always_ff @(posedge clk) begin
        strb_q <= rd_strobe;
    end

    // General toggle: flips on each read while running or timed out.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       tgl <= 1'b0;
        else if (fire && active) tgl <= !tgl;
    end

    // Erase toggle: flips on reads of the erased sector during any erase phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) etgl <= 1'b0;
        else if (fire && (kind == OP_ERASE) && in_sector && (st != ST_IDLE))
            etgl <= !etgl;
    end
endmodule

// File: rtl/eo_status_mux.sv
// Builds the status word and registers either it or array data on each read.
// Assumes DATA_W >= 8; upper bits of the status word are zero.
module eo_status_mux
    import eo_poll_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  eo_state_t         st,
    input  eo_kind_t          kind,
    input  logic              in_sector,
    input  logic              pd7,
    input  logic              tgl,
    input  logic              etgl,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    logic              overlay;
    logic              poll_bit;
    logic [DATA_W-1:0] status_word;

    // Overlay applies when running, timed out, or reading an erase-suspended sector.
    always_comb begin
        overlay = (st == ST_BUSY) || (st == ST_FAIL) ||
                  ((st == ST_SUSP) && (kind == OP_ERASE) && in_sector);
        if (st == ST_SUSP)         poll_bit = 1'b1;
        else if (kind == OP_ERASE) poll_bit = 1'b0;
        else                       poll_bit = !pd7;
    end

    // Assemble the status word; unused bits stay zero.
    always_comb begin
        status_word           = '0;
        status_word[BIT_POLL] = poll_bit;
        status_word[BIT_TGL]  = tgl;
        status_word[BIT_TMO]  = (st == ST_FAIL);
        status_word[BIT_ETGL] = etgl;
    end

    // Output register, loaded only on a read strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n)    rd_data <= '0;
        else if (fire) rd_data <= overlay ? status_word : array_data;
    end
endmodule

// File: rtl/eo_poll_status.sv
// Top of the polling status block: tracks the embedded operation, generates
// toggle bits per read and overlays the status word on the read data.
// Assumes the host presents only the sector field of the read address.
module eo_poll_status
    import eo_poll_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_kind,
    input  logic [SECT_W-1:0] op_sector,
    input  logic              op_data7,
    input  logic              op_done,
    input  logic              op_timeout,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              reset_cmd,
    input  logic              rd_strobe,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready
);
    localparam int WORD_OK = (DATA_W >= STATUS_MIN_W) ? 1 : 0;

    eo_state_t         st;
    eo_kind_t          kind;
    logic [SECT_W-1:0] sect;
    logic              pd7;
    logic              clr_tgl;
    logic              fire;
    logic              tgl;
    logic              etgl;
    logic              in_sector;

    // Parameter sanity check at elaboration time.
    initial begin
        if (WORD_OK == 0) $display("eo_poll_status: DATA_W below status width");
    end

    assign in_sector = (rd_sect == sect);

    eo_op_fsm #(.SECT_W(SECT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_kind    (eo_kind_t'(op_kind)),
        .op_sector  (op_sector),
        .op_data7   (op_data7),
        .op_done    (op_done),
        .op_timeout (op_timeout),
        .suspend_req(suspend_req),
        .resume_req (resume_req),
        .reset_cmd  (reset_cmd),
        .st         (st),
        .kind       (kind),
        .sect       (sect),
        .pd7        (pd7),
        .clr_tgl    (clr_tgl),
        .ready      (ready)
    );

    eo_toggle_gen u_tgl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_strobe(rd_strobe),
        .clr      (clr_tgl),
        .st       (st),
        .kind     (kind),
        .in_sector(in_sector),
        .fire     (fire),
        .tgl      (tgl),
        .etgl     (etgl)
    );

    eo_status_mux #(.DATA_W(DATA_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .st        (st),
        .kind      (kind),
        .in_sector (in_sector),
        .pd7       (pd7),
        .tgl       (tgl),
        .etgl      (etgl),
        .array_data(array_data),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/eo_poll_status_chk.sv
// Temporal checks on the polling status block, bound onto its top module.
module eo_poll_status_chk
    import eo_poll_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic              reset_cmd,
    input logic              ready,
    input logic [DATA_W-1:0] rd_data,
    input eo_state_t         st
);
    // R3: read data only moves on a strobe rise.
    assert_data_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rd_strobe) |=> $stable(rd_data));

    // R1: a read while running yields only the defined status bits.
    assert_overlay_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_strobe) && (st == ST_BUSY)) |=>
        ((rd_data[DATA_W-1:8] == '0) && (rd_data[4:3] == 2'b00) && (rd_data[1:0] == 2'b00)));

    // R6: a timed-out operation stays there until a reset command.
    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_FAIL) && !reset_cmd) |=> (st == ST_FAIL));

    // R6: reads while timed out show the timeout flag.
    assert_timeout_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_strobe) && (st == ST_FAIL)) |=> rd_data[BIT_TMO]);

    // R8: ready is low while running or timed out.
    assert_busy_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_BUSY) || (st == ST_FAIL)) |-> !ready);

    // R8: ready rises only after a cycle in idle or suspended.
    assert_ready_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (($past(st) == ST_IDLE) || ($past(st) == ST_SUSP)));
endmodule

bind eo_poll_status eo_poll_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_strobe(rd_strobe),
    .reset_cmd(reset_cmd),
    .ready    (ready),
    .rd_data  (rd_data),
    .st       (st)
);

// File: tb/sim_eo_poll_status.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module sim_eo_poll_status;
    localparam int DW = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 0, op_kind = 0, op_data7 = 0;
    logic [SW-1:0] op_sector = '0;
    logic          op_done = 0, op_timeout = 0, suspend_req = 0, resume_req = 0, reset_cmd = 0;
    logic          rd_strobe = 0;
    logic [SW-1:0] rd_sect = '0;
    logic [DW-1:0] array_data;
    logic [DW-1:0] rd_data;
    logic          ready;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] arr(input logic [SW-1:0] s);
        return {4'hC, s, 8'h3C};
    endfunction

    assign array_data = arr(rd_sect);

    eo_poll_status #(.DATA_W(DW), .SECT_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_sector(op_sector), .op_data7(op_data7), .op_done(op_done),
        .op_timeout(op_timeout), .suspend_req(suspend_req), .resume_req(resume_req),
        .reset_cmd(reset_cmd), .rd_strobe(rd_strobe), .rd_sect(rd_sect),
        .array_data(array_data), .rd_data(rd_data), .ready(ready)
    );

    // Reference model: 0 idle, 1 busy, 2 suspended, 3 timed out.
    int            m_st;
    bit            m_kind, m_p7, m_t6, m_t2, m_sq, m_rdy;
    logic [SW-1:0] m_sec;
    logic [DW-1:0] m_rd;

    always @(posedge clk) begin
        bit fire, insec, ovl;
        if (!rst_n) begin
            m_st = 0; m_t6 = 0; m_t2 = 0; m_rd = '0; m_rdy = 1;
            m_sq = rd_strobe; m_kind = 0; m_p7 = 0; m_sec = '0;
        end else begin
            fire  = rd_strobe && !m_sq;
            m_sq  = rd_strobe;
            insec = (rd_sect == m_sec);
            if (fire) begin
                ovl = (m_st == 1) || (m_st == 3) || ((m_st == 2) && m_kind && insec);
                if (ovl) begin
                    m_rd    = '0;
                    m_rd[7] = (m_st == 2) ? 1'b1 : (m_kind ? 1'b0 : !m_p7);
                    m_rd[6] = m_t6;
                    m_rd[5] = (m_st == 3);
                    m_rd[2] = m_t2;
                end else begin
                    m_rd = array_data;
                end
                if (m_st == 1 || m_st == 3) m_t6 = !m_t6;
                if (m_kind && insec && m_st != 0) m_t2 = !m_t2;
            end
            if ((m_st == 0 && op_start) || (m_st == 2 && resume_req)) m_rdy = 0;
            else m_rdy = (m_st == 0) || (m_st == 2);
            case (m_st)
                0: if (op_start) begin
                    m_st = 1; m_kind = op_kind; m_p7 = op_data7; m_sec = op_sector;
                    m_t6 = 0; m_t2 = 0;
                end
                1: begin
                    if (op_timeout)       m_st = 3;
                    else if (op_done)     m_st = 0;
                    else if (suspend_req) m_st = 2;
                end
                2: if (resume_req) m_st = 1;
                default: if (reset_cmd) m_st = 0;
            endcase
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks += 2;
            if (rd_data !== m_rd) begin
                n_errors++;
                $display("FAIL %s model rd_data act %h exp %h t=%0t", cur_req, rd_data, m_rd, $time);
            end
            if (ready !== m_rdy) begin
                n_errors++;
                $display("FAIL R8 model ready act %b exp %b t=%0t", ready, m_rdy, $time);
            end
        end
    end

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s act %h exp %h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_read(input logic [SW-1:0] s, input logic [DW-1:0] exp, input string tag);
        @(negedge clk); rd_sect = s; rd_strobe = 1;
        @(negedge clk); chk(rd_data, exp, tag); rd_strobe = 0;
        @(negedge clk);
    endtask

    task automatic start_op(input logic k, input logic [SW-1:0] s, input logic d7);
        @(negedge clk); op_start = 1; op_kind = k; op_sector = s; op_data7 = d7;
        @(negedge clk); op_start = 0;
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog act running exp finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk({15'd0, ready}, 16'd1, "R8 reset ready");
        chk(rd_data, 16'd0, "R8 reset data");

        cur_req = "R10";
        do_read(5, arr(5), "R10 idle read");

        // Program, data bit 7 = 1
        cur_req = "R1";
        start_op(0, 2, 1);
        chk({15'd0, ready}, 16'd0, "R8 busy after start");
        do_read(9, 16'h0000, "R1 any sector status");
        do_read(2, 16'h0040, "R4 toggle alternates");
        do_read(0, 16'h0000, "R2 program poll bit");
        cur_req = "R9";
        start_op(1, 2, 0);
        do_read(9, 16'h0040, "R9 start ignored while busy");
        @(negedge clk); reset_cmd = 1; @(negedge clk); reset_cmd = 0;
        do_read(1, 16'h0000, "R9 reset ignored while busy");
        @(negedge clk); op_done = 1; @(negedge clk); op_done = 0;
        chk({15'd0, ready}, 16'd0, "R8 ready one cycle late");
        @(negedge clk);
        chk({15'd0, ready}, 16'd1, "R8 ready after done");
        cur_req = "R10";
        do_read(2, arr(2), "R10 array after completion");

        // Program, data bit 7 = 0
        cur_req = "R2";
        start_op(0, 4, 0);
        do_read(4, 16'h0080, "R2 inverted bit7");
        @(negedge clk); op_done = 1; @(negedge clk); op_done = 0;
        repeat (2) @(negedge clk);

        // Erase sector 3
        cur_req = "R5";
        start_op(1, 3, 0);
        do_read(3, 16'h0000, "R2 erase poll 0");
        do_read(7, 16'h0044, "R5 other sector");
        do_read(3, 16'h0004, "R5 erase toggle held off-sector");
        cur_req = "R7";
        @(negedge clk); suspend_req = 1; @(negedge clk); suspend_req = 0;
        @(negedge clk);
        chk({15'd0, ready}, 16'd1, "R7 ready while suspended");
        do_read(7, arr(7), "R7 array while suspended");
        do_read(3, 16'h00C0, "R7 suspended sector status");
        do_read(3, 16'h00C4, "R5 toggles while suspended");
        @(negedge clk); resume_req = 1; @(negedge clk); resume_req = 0;
        chk({15'd0, ready}, 16'd0, "R8 busy after resume");
        do_read(8, 16'h0040, "R7 overlay restored");

        // Timeout
        cur_req = "R6";
        @(negedge clk); op_timeout = 1; @(negedge clk); op_timeout = 0;
        do_read(8, 16'h0020, "R6 timeout flag");
        @(negedge clk); op_done = 1; @(negedge clk); op_done = 0;
        @(negedge clk); suspend_req = 1; @(negedge clk); suspend_req = 0;
        do_read(3, 16'h0060, "R6 done and suspend ignored");
        chk({15'd0, ready}, 16'd0, "R6 still busy");
        @(negedge clk); reset_cmd = 1; @(negedge clk); reset_cmd = 0;
        @(negedge clk);
        chk({15'd0, ready}, 16'd1, "R6 ready after reset cmd");
        do_read(3, arr(3), "R6 array after reset cmd");

        // Priority
        cur_req = "R9";
        start_op(0, 1, 1);
        @(negedge clk); op_timeout = 1; op_done = 1; suspend_req = 1;
        @(negedge clk); op_timeout = 0; op_done = 0; suspend_req = 0;
        do_read(1, 16'h0020, "R9 timeout beats done");
        @(negedge clk); reset_cmd = 1; @(negedge clk); reset_cmd = 0;
        repeat (2) @(negedge clk);
        start_op(1, 6, 0);
        @(negedge clk); op_done = 1; suspend_req = 1;
        @(negedge clk); op_done = 0; suspend_req = 0;
        @(negedge clk);
        chk({15'd0, ready}, 16'd1, "R9 done ready");
        do_read(6, arr(6), "R9 done beats suspend");

        repeat (3) @(negedge clk);
        report();
    end
endmodule